// File: doc/BRIEF.md
# Front-End Link Bus Controller

This block sits at the detector electronics end of a synchronous, half-duplex, 32-bit link bus. The other side of the bus is a serial link source unit. The front end supplies the clock. The link side always decides who owns the bus: it drives an active-low bus enable and a direction input. The front end only answers.

Every bus word travels with an active-low transfer-enable. A second active-low flag, the control qualifier, marks command and status words. Payload words leave that flag released.

The controller decodes commands that arrive from the link and performs four kinds of transaction:
- **Control write.** It latches one word into a control register and sends nothing back.
- **Status read.** It returns one status word once the bus has been turned around.
- **Event readout.** Readout mode is switched on by a ready-to-receive command. The block then streams event blocks from a first-word-fall-through source. Each block ends with a status word. The stream pauses whenever the active-low link-full input is asserted.
- **Block download.** It forwards payload words to a downstream sink, and holds them off with its active-low busy output.

The bidirectional lines appear as separate input, output and output-enable signals. The pad ring builds the tristate buffers from them.

Top module: `fe_linkbus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all three output enables are low, `busy_n_o` is high, `ctrl_word_o` is zero, `dl_valid_o` is low and `src_pop_o` is low.
- R2: The output enables are high only while `bus_en_n_i` is low and `bus_dir_i` is high (1 = front end to link). They are never high in the first cycle of such ownership, and they fall in the very cycle that the enable rises.
- R3: A link word with transfer-enable low, qualifier low, bits 7:0 = 0xC4 and bit 8 = 0 is copied whole into `ctrl_word_o` from the next cycle on. No other word changes it, and the front end sends no reply.
- R4: A command with bits 7:0 = 0xC4 and bit 8 = 1 causes exactly one word equal to `fe_status_i` to be sent, with qualifier low, once the front end owns the bus.
- R5: After a command with opcode 0x14, each source event is sent in source order with qualifier high. It is followed by one word equal to `fe_status_i`, sent with qualifier low.
- R6: A word counts as transferred only at an edge where `link_full_n_i` is high. While it is low, the presented data word stays unchanged and `src_pop_o` stays low.
- R7: Between the transfer of an event's closing status word and the transfer of the next event's first word, more than 16 clock edges pass.
- R8: After a command with opcode 0xB4, no further event word is sent, even while the source holds data.
- R9: After a command with opcode 0xD4, every link payload word (qualifier high) appears on `dl_data_o` with `dl_valid_o` high in the next cycle. This continues until opcode 0xB4 arrives; after that, payload words are ignored.
- R10: `busy_n_o` is low exactly when a block download is open and `dl_ready_i` is low.
- R11: When a status reply and an event start are both pending at the moment the front end takes the bus, the status word is sent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock supplied by the front end |
| rst | input | 1 | Synchronous active-high reset |
| bus_en_n_i | input | 1 | Bus enable from the link side, active low |
| bus_dir_i | input | 1 | Bus direction from the link side, 1 = front end drives |
| link_full_n_i | input | 1 | Link full, active low; stalls outgoing words |
| busy_n_o | output | 1 | Front-end busy, active low; stalls downloads |
| lb_data_i | input | 32 | Data lines as received |
| lb_data_o | output | 32 | Data lines as driven |
| lb_data_oe | output | 1 | Output enable for the data lines |
| lb_ten_n_i | input | 1 | Transfer-enable as received, active low |
| lb_ten_n_o | output | 1 | Transfer-enable as driven, active low |
| lb_ten_oe | output | 1 | Output enable for transfer-enable |
| lb_ctl_n_i | input | 1 | Control qualifier as received, active low |
| lb_ctl_n_o | output | 1 | Control qualifier as driven, active low |
| lb_ctl_oe | output | 1 | Output enable for the control qualifier |
| src_data_i | input | 32 | Head word of the event source |
| src_valid_i | input | 1 | Event source holds a word |
| src_last_i | input | 1 | Head word is the last of its event |
| src_pop_o | output | 1 | Head word was transferred this cycle |
| fe_status_i | input | 32 | Status word returned on reads and after events |
| ctrl_word_o | output | 32 | Control register |
| dl_data_o | output | 32 | Downloaded payload word |
| dl_valid_o | output | 1 | Downloaded payload word is valid |
| dl_ready_i | input | 1 | Download sink can accept words |

## Verification
A status-read reply and the start of an event can both be waiting when the link hands the bus over.

To provoke this, the bench issues a status read followed by ready-to-receive while the source already holds an event, and only then turns the bus around. It judges the outcome from the transfer log: the first word must be the status word with the qualifier low. The full event and its closing status word must follow, in order.

A second overlap comes from random link-full stalls. These can fall in the same cycle as the last data word or the closing status word, and the log must still show every word exactly once.

// File: rtl/fe_lb_pkg.sv
package fe_lb_pkg;

    localparam int LB_DATA_W = 32;
    localparam int LB_OPC_W  = 8;

    localparam logic [LB_OPC_W-1:0] OPC_CTRL   = 8'hC4;
    localparam logic [LB_OPC_W-1:0] OPC_RDY    = 8'h14;
    localparam logic [LB_OPC_W-1:0] OPC_EOB    = 8'hB4;
    localparam logic [LB_OPC_W-1:0] OPC_BLKWR  = 8'hD4;
    localparam int                  RD_SEL_BIT = 8;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_CTRLWR,
        CMD_STATRD,
        CMD_RDYRX,
        CMD_EOB,
        CMD_BLKWR
    } cmd_kind_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_REPLY,
        TX_DATA,
        TX_CLOSE,
        TX_GAP
    } tx_state_e;

    typedef struct packed {
        logic [LB_DATA_W-1:0] data;
        logic                 ten_n;
        logic                 ctl_n;
    } lb_word_t;

    function automatic cmd_kind_e decode_cmd(input logic [LB_DATA_W-1:0] w);
        cmd_kind_e k;
        case (w[LB_OPC_W-1:0])
            OPC_CTRL:  k = w[RD_SEL_BIT] ? CMD_STATRD : CMD_CTRLWR;
            OPC_RDY:   k = CMD_RDYRX;
            OPC_EOB:   k = CMD_EOB;
            OPC_BLKWR: k = CMD_BLKWR;
            default:   k = CMD_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/fe_lb_turn.sv
module fe_lb_turn (
    input  logic clk,
    input  logic rst,
    input  logic bus_en_n,
    input  logic bus_dir,
    output logic own_now,
    output logic own_ok
);
    logic own_q;

    assign own_now = !bus_en_n && bus_dir;

    always_ff @(posedge clk) begin
        if (rst) own_q <= 1'b0;
        else     own_q <= own_now;
    end

    // drive only after one full cycle of ownership; release combinationally
    assign own_ok = own_now && own_q;
endmodule

// File: rtl/fe_lb_rx.sv
module fe_lb_rx
    import fe_lb_pkg::*;
#(
    parameter int DATA_W = LB_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en_n,
    input  logic              bus_dir,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_ten_n,
    input  logic              rx_ctl_n,
    input  logic              dl_ready,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              stat_req,
    output logic              readout_on,
    output logic [DATA_W-1:0] dl_data,
    output logic              dl_valid,
    output logic              busy_n
);
    logic      word_in;
    logic      is_cmd;
    logic      is_pay;
    cmd_kind_e kind;
    logic      blk_open;

    assign word_in = !bus_en_n && !bus_dir && !rx_ten_n;
    assign is_cmd  = word_in && !rx_ctl_n;
    assign is_pay  = word_in && rx_ctl_n;
    assign kind    = is_cmd ? decode_cmd(rx_data) : CMD_NONE;

    assign stat_req = (kind == CMD_STATRD);
    assign busy_n   = !(blk_open && !dl_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_word  <= '0;
            readout_on <= 1'b0;
            blk_open   <= 1'b0;
            dl_valid   <= 1'b0;
            dl_data    <= '0;
        end else begin
            dl_valid <= is_pay && blk_open;
            if (is_pay && blk_open) dl_data <= rx_data;
            case (kind)
                CMD_CTRLWR: ctrl_word  <= rx_data;
                CMD_RDYRX:  readout_on <= 1'b1;
                CMD_BLKWR:  blk_open   <= 1'b1;
                CMD_EOB: begin
                    readout_on <= 1'b0;
                    blk_open   <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fe_lb_tx.sv
module fe_lb_tx
    import fe_lb_pkg::*;
#(
    parameter int DATA_W     = LB_DATA_W,
    parameter int GAP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              own_now,
    input  logic              own_ok,
    input  logic              link_full_n,
    input  logic              stat_req,
    input  logic              readout_on,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    input  logic              src_last,
    input  logic [DATA_W-1:0] fe_status,
    output logic              src_pop,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ten_n,
    output logic              out_ctl_n
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);

    tx_state_e  state;
    logic       pend_stat;
    logic [CNT_W-1:0] gap_cnt;
    logic       present;
    logic       xfer;
    lb_word_t   wd;

    always_comb begin
        wd = '{data: '0, ten_n: 1'b1, ctl_n: 1'b1};
        case (state)
            TX_REPLY: wd = '{data: fe_status, ten_n: 1'b0, ctl_n: 1'b0};
            TX_CLOSE: wd = '{data: fe_status, ten_n: 1'b0, ctl_n: 1'b0};
            TX_DATA:  wd = '{data: src_data, ten_n: !src_valid, ctl_n: 1'b1};
            default:  ;
        endcase
    end

    assign present   = !wd.ten_n;
    assign xfer      = own_ok && link_full_n && present;
    assign src_pop   = (state == TX_DATA) && xfer;
    assign out_data  = wd.data;
    assign out_ten_n = wd.ten_n;
    assign out_ctl_n = wd.ctl_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            pend_stat <= 1'b0;
            gap_cnt   <= '0;
        end else begin
            if (stat_req)                           pend_stat <= 1'b1;
            else if (state == TX_REPLY && xfer)     pend_stat <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (own_now && pend_stat)                   state <= TX_REPLY;
                    else if (own_now && readout_on && src_valid) state <= TX_DATA;
                end
                TX_REPLY: if (xfer) state <= TX_IDLE;
                TX_DATA:  if (xfer && src_last) state <= TX_CLOSE;
                TX_CLOSE: if (xfer) begin
                    state   <= TX_GAP;
                    gap_cnt <= CNT_W'(GAP_CYCLES - 1);
                end
                TX_GAP: begin
                    if (gap_cnt == '0) state <= TX_IDLE;
                    else               gap_cnt <= gap_cnt - 1'b1;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fe_linkbus_ctrl.sv
module fe_linkbus_ctrl
    import fe_lb_pkg::*;
#(
    parameter int DATA_W     = LB_DATA_W,
    parameter int GAP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en_n_i,
    input  logic              bus_dir_i,
    input  logic              link_full_n_i,
    output logic              busy_n_o,
    input  logic [DATA_W-1:0] lb_data_i,
    output logic [DATA_W-1:0] lb_data_o,
    output logic              lb_data_oe,
    input  logic              lb_ten_n_i,
    output logic              lb_ten_n_o,
    output logic              lb_ten_oe,
    input  logic              lb_ctl_n_i,
    output logic              lb_ctl_n_o,
    output logic              lb_ctl_oe,
    input  logic [DATA_W-1:0] src_data_i,
    input  logic              src_valid_i,
    input  logic              src_last_i,
    output logic              src_pop_o,
    input  logic [DATA_W-1:0] fe_status_i,
    output logic [DATA_W-1:0] ctrl_word_o,
    output logic [DATA_W-1:0] dl_data_o,
    output logic              dl_valid_o,
    input  logic              dl_ready_i
);
    logic own_now, own_ok, stat_req, readout_on;

    fe_lb_turn u_turn (
        .clk(clk), .rst(rst),
        .bus_en_n(bus_en_n_i), .bus_dir(bus_dir_i),
        .own_now(own_now), .own_ok(own_ok)
    );

    fe_lb_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst),
        .bus_en_n(bus_en_n_i), .bus_dir(bus_dir_i),
        .rx_data(lb_data_i), .rx_ten_n(lb_ten_n_i), .rx_ctl_n(lb_ctl_n_i),
        .dl_ready(dl_ready_i),
        .ctrl_word(ctrl_word_o), .stat_req(stat_req), .readout_on(readout_on),
        .dl_data(dl_data_o), .dl_valid(dl_valid_o), .busy_n(busy_n_o)
    );

    fe_lb_tx #(.DATA_W(DATA_W), .GAP_CYCLES(GAP_CYCLES)) u_tx (
        .clk(clk), .rst(rst),
        .own_now(own_now), .own_ok(own_ok),
        .link_full_n(link_full_n_i),
        .stat_req(stat_req), .readout_on(readout_on),
        .src_data(src_data_i), .src_valid(src_valid_i), .src_last(src_last_i),
        .fe_status(fe_status_i),
        .src_pop(src_pop_o),
        .out_data(lb_data_o), .out_ten_n(lb_ten_n_o), .out_ctl_n(lb_ctl_n_o)
    );

    assign lb_data_oe = own_ok;
    assign lb_ten_oe  = own_ok;
    assign lb_ctl_oe  = own_ok;
endmodule

// File: rtl/fe_linkbus_ctrl_chk.sv
module fe_linkbus_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en_n_i,
    input logic              bus_dir_i,
    input logic              link_full_n_i,
    input logic              busy_n_o,
    input logic [DATA_W-1:0] lb_data_i,
    input logic [DATA_W-1:0] lb_data_o,
    input logic              lb_data_oe,
    input logic              lb_ten_n_i,
    input logic              lb_ten_n_o,
    input logic              lb_ctl_n_i,
    input logic              lb_ctl_n_o,
    input logic              src_pop_o,
    input logic [DATA_W-1:0] ctrl_word_o,
    input logic              dl_valid_o,
    input logic              dl_ready_i
);
    // R2
    drive_own_chk: assert property (@(posedge clk) disable iff (rst)
        lb_data_oe |-> (!bus_en_n_i && bus_dir_i));

    // R2
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        lb_data_oe |-> $past(!bus_en_n_i && bus_dir_i));

    // R6
    pop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        src_pop_o |-> (link_full_n_i && lb_data_oe && !lb_ten_n_o && lb_ctl_n_o));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lb_data_oe && !lb_ten_n_o && lb_ctl_n_o && !link_full_n_i) ##1 (lb_data_oe && lb_ctl_n_o)
        |-> $stable(lb_data_o));

    // R3
    ctrl_src_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word_o) |-> $past(!bus_en_n_i && !bus_dir_i && !lb_ten_n_i && !lb_ctl_n_i
                                        && lb_data_i[7:0] == 8'hC4 && !lb_data_i[8]));

    // R9
    dl_src_chk: assert property (@(posedge clk) disable iff (rst)
        dl_valid_o |-> $past(!bus_en_n_i && !bus_dir_i && !lb_ten_n_i && lb_ctl_n_i));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_n_o |-> !dl_ready_i);
endmodule

bind fe_linkbus_ctrl fe_linkbus_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .bus_en_n_i(bus_en_n_i), .bus_dir_i(bus_dir_i),
    .link_full_n_i(link_full_n_i), .busy_n_o(busy_n_o),
    .lb_data_i(lb_data_i), .lb_data_o(lb_data_o), .lb_data_oe(lb_data_oe),
    .lb_ten_n_i(lb_ten_n_i), .lb_ten_n_o(lb_ten_n_o),
    .lb_ctl_n_i(lb_ctl_n_i), .lb_ctl_n_o(lb_ctl_n_o),
    .src_pop_o(src_pop_o), .ctrl_word_o(ctrl_word_o),
    .dl_valid_o(dl_valid_o), .dl_ready_i(dl_ready_i)
);

// File: tb/fe_linkbus_ctrl_bench.sv
`timescale 1ns/1ps
module fe_linkbus_ctrl_bench;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic         bus_en_n = 1'b1, bus_dir = 1'b0, lf_n = 1'b1;
    logic         busy_n;
    logic [W-1:0] d_in = '0, d_out;
    logic         d_oe, ten_in = 1'b1, ten_out, ten_oe, ctl_in = 1'b1, ctl_out, ctl_oe;
    logic [W-1:0] src_data;
    logic         src_valid, src_last, src_pop;
    logic [W-1:0] fe_status = 32'h5A5A_0001;
    logic [W-1:0] ctrl_word, dl_data;
    logic         dl_valid, dl_ready = 1'b1;

    logic [W-1:0] src_mem [0:127];
    logic         src_lst [0:127];
    int           src_n = 0, src_idx = 0;

    assign src_valid = (src_idx < src_n);
    assign src_data  = src_valid ? src_mem[src_idx] : '0;
    assign src_last  = src_valid ? src_lst[src_idx] : 1'b0;

    fe_linkbus_ctrl u_fe_linkbus_ctrl (
        .clk(clk), .rst(rst),
        .bus_en_n_i(bus_en_n), .bus_dir_i(bus_dir), .link_full_n_i(lf_n),
        .busy_n_o(busy_n),
        .lb_data_i(d_in), .lb_data_o(d_out), .lb_data_oe(d_oe),
        .lb_ten_n_i(ten_in), .lb_ten_n_o(ten_out), .lb_ten_oe(ten_oe),
        .lb_ctl_n_i(ctl_in), .lb_ctl_n_o(ctl_out), .lb_ctl_oe(ctl_oe),
        .src_data_i(src_data), .src_valid_i(src_valid), .src_last_i(src_last),
        .src_pop_o(src_pop), .fe_status_i(fe_status),
        .ctrl_word_o(ctrl_word), .dl_data_o(dl_data), .dl_valid_o(dl_valid),
        .dl_ready_i(dl_ready)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    logic bw_exp = 1'b0, prev_own = 1'b0, prev_stall = 1'b0;
    logic [W-1:0] prev_word;
    logic [W-1:0] rx_w [0:255];
    logic         rx_c [0:255];
    int           rx_t [0:255];
    int           nrx = 0;
    logic [W-1:0] exp_w [0:255];
    logic         exp_c [0:255];
    int           nexp = 0;

    task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_busy(input logic open, input logic rdy);
        return !(open && !rdy);
    endfunction

    function automatic logic [W-1:0] mk_ctrl(input logic [W-1:0] r);
        return {r[W-1:9], 1'b0, 8'hC4};
    endfunction

    // called right after a falling edge with inputs already set
    task automatic step();
        logic pop_s;
        #8;
        if (d_oe && !(!bus_en_n && bus_dir)) check(1'b0, "R2 drive without ownership", W'(d_oe), 0);
        if (d_oe && !prev_own)               check(1'b0, "R2 no turnaround cycle", W'(d_oe), 0);
        if (!(ten_oe == d_oe && ctl_oe == d_oe)) check(1'b0, "R2 enables differ", W'({ten_oe, ctl_oe}), W'({d_oe, d_oe}));
        if (busy_n !== exp_busy(bw_exp, dl_ready)) check(1'b0, "R10 busy", W'(busy_n), W'(exp_busy(bw_exp, dl_ready)));
        if (d_oe && !lf_n && src_pop) check(1'b0, "R6 pop while full", W'(src_pop), 0);
        if (prev_stall && d_oe && !ten_out && ctl_out && d_out !== prev_word)
            check(1'b0, "R6 stalled word changed", d_out, prev_word);
        prev_stall = d_oe && !ten_out && ctl_out && !lf_n;
        prev_word  = d_out;
        if (d_oe && !ten_out && lf_n && nrx < 256) begin
            rx_w[nrx] = d_out; rx_c[nrx] = !ctl_out; rx_t[nrx] = cyc; nrx++;
        end
        prev_own = !bus_en_n && bus_dir;
        pop_s = src_pop;
        @(posedge clk);
        #1;
        if (pop_s) src_idx++;
        cyc++;
        @(negedge clk);
    endtask

    task automatic link_word(input logic [W-1:0] w, input logic is_ctl);
        bus_en_n = 1'b0; bus_dir = 1'b0; ten_in = 1'b0; ctl_in = !is_ctl; d_in = w;
        step();
        ten_in = 1'b1; ctl_in = 1'b1;
    endtask

    task automatic give_bus(input int n, input int full_pct);
        bus_en_n = 1'b1; step();
        bus_dir = 1'b1; bus_en_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            lf_n = ($urandom % 100) >= full_pct;
            step();
        end
        lf_n = 1'b1;
        bus_en_n = 1'b1;
        #1 check(d_oe == 1'b0, "R2 release on enable", W'(d_oe), 0);
        step();
        bus_dir = 1'b0;
    endtask

    task automatic add_event(input int len);
        for (int i = 0; i < len; i++) begin
            src_mem[src_n] = $urandom; src_lst[src_n] = (i == len - 1);
            exp_w[nexp] = src_mem[src_n]; exp_c[nexp] = 1'b0; nexp++;
            src_n++;
        end
        exp_w[nexp] = fe_status; exp_c[nexp] = 1'b1; nexp++;
    endtask

    task automatic compare_log(input string req);
        check(nrx == nexp, req, W'(nrx), W'(nexp));
        for (int i = 0; i < nexp && i < nrx; i++) begin
            check(rx_w[i] == exp_w[i], req, rx_w[i], exp_w[i]);
            check(rx_c[i] == exp_c[i], req, W'(rx_c[i]), W'(exp_c[i]));
        end
    endtask

    logic done = 1'b0;
    initial begin
        #(20 * 200000);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w;
        void'($urandom(32'd1234));
        @(negedge clk);
        step(); step();
        // R1 reset state
        check(d_oe == 0 && ten_oe == 0 && ctl_oe == 0, "R1 enables", W'({d_oe, ten_oe, ctl_oe}), 0);
        check(busy_n == 1 && dl_valid == 0 && src_pop == 0, "R1 flags", W'({busy_n, dl_valid, src_pop}), W'(3'b100));
        check(ctrl_word == '0, "R1 ctrl", ctrl_word, 0);
        rst = 1'b0;
        step();
        check(d_oe == 0 && ctrl_word == '0, "R1 after release", ctrl_word, 0);

        // R3 control writes, directed then random
        link_word(32'h1234_56C4, 1'b1);
        check(ctrl_word == 32'h1234_56C4, "R3 ctrl write", ctrl_word, 32'h1234_56C4);
        for (int k = 0; k < 5; k++) begin
            w = mk_ctrl($urandom);
            link_word(w, 1'b1);
            check(ctrl_word == w, "R3 ctrl write random", ctrl_word, w);
        end
        nrx = 0; nexp = 0;
        give_bus(6, 0);
        check(nrx == 0, "R3 no reply to control write", W'(nrx), 0);
        w = ctrl_word;

        // R4 status read
        fe_status = 32'hCAFE_0102;
        link_word(32'h0000_01C4, 1'b1);
        check(ctrl_word == w, "R3 status read leaves ctrl", ctrl_word, w);
        give_bus(10, 0);
        check(nrx == 1, "R4 one reply", W'(nrx), 1);
        check(rx_w[0] == 32'hCAFE_0102 && rx_c[0], "R4 status word", rx_w[0], 32'hCAFE_0102);

        // R5 R6 R7 readout of two events with random link-full
        nrx = 0; nexp = 0; fe_status = 32'h5A5A_0001;
        add_event(1 + ($urandom % 8));
        add_event(1 + ($urandom % 8));
        link_word(32'h0000_0014, 1'b1);
        give_bus(140, 30);
        compare_log("R5 R6 event stream");
        for (int i = 1; i < nrx; i++)
            if (rx_c[i - 1] && !rx_c[i])
                check(rx_t[i] - rx_t[i - 1] > 16, "R7 gap", W'(rx_t[i] - rx_t[i - 1]), 17);

        // R8 end of block stops readout
        link_word(32'h0000_00B4, 1'b1);
        nrx = 0; nexp = 0;
        add_event(4);
        give_bus(40, 0);
        check(nrx == 0, "R8 no data after end", W'(nrx), 0);
        check(src_idx == src_n - 4, "R8 source untouched", W'(src_idx), W'(src_n - 4));

        // R11 priority: status and event both pending
        nrx = 0; nexp = 0; fe_status = 32'h7777_0003;
        exp_w[0] = fe_status; exp_c[0] = 1'b1; nexp = 1;
        for (int i = src_idx; i < src_n; i++) begin
            exp_w[nexp] = src_mem[i]; exp_c[nexp] = 1'b0; nexp++;
        end
        exp_w[nexp] = fe_status; exp_c[nexp] = 1'b1; nexp++;
        link_word(32'h0000_01C4, 1'b1);
        link_word(32'h0000_0014, 1'b1);
        give_bus(40, 0);
        check(nrx > 0 && rx_c[0] && rx_w[0] == fe_status, "R11 status first", rx_w[0], fe_status);
        compare_log("R11 then event");
        link_word(32'h0000_00B4, 1'b1);

        // R9 R10 block download
        link_word(32'h0000_00D4, 1'b1);
        bw_exp = 1'b1;
        for (int k = 0; k < 20; k++) begin
            dl_ready = $urandom % 2;
            if (k % 4 == 3) begin
                bus_en_n = 1'b0; bus_dir = 1'b0; ten_in = 1'b1;
                step();
                check(dl_valid == 0, "R9 no word no valid", W'(dl_valid), 0);
            end else begin
                w = $urandom;
                link_word(w, 1'b0);
                check(dl_valid == 1 && dl_data == w, "R9 download word", dl_data, w);
            end
        end
        dl_ready = 1'b0;
        link_word(32'h0000_00B4, 1'b1);
        bw_exp = 1'b0;
        link_word(32'h0BAD_0BAD, 1'b0);
        check(dl_valid == 0, "R9 payload ignored after end", W'(dl_valid), 0);
        check(busy_n == 1, "R10 busy released after end", W'(busy_n), 1);
        dl_ready = 1'b1;
        bus_en_n = 1'b1;
        step();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule